// File: doc/BRIEF.md
# Element-Aliased Vector Register File

This block holds 128 registers of 64 bits and treats them as one flat, little-endian byte store of 1024 bytes. A caller names an element with three values: a base register, an element index and an element width of 8, 16, 32 or 64 bits. The block turns these into a register number and a byte lane. Because the index is scaled by the element size and added to the base, a large index simply runs on into the registers that follow the base. Elements of every width are views of the same bytes, so a write at one width is seen at once by reads at any other width.

There is one combinational read port and one write port that commits on the rising clock edge. A write changes only the bytes that the element covers. When an access would land past the last register, the port raises its error flag. An erroneous write changes nothing, and an erroneous read returns zero.

Top module: `elem_regfile`

## Requirements
- R1: After reset every byte of the store reads as zero.
- R2: The element's byte offset is base*8 + index*size. The register is offset/8 and the byte lane is offset%8. Byte lane k holds bits [8k+7:8k] of the register, and the element's least significant byte sits in its lowest lane.
- R3: The width codes are 0 for 8 bits, 1 for 16 bits, 2 for 32 bits and 3 for 64 bits.
- R4: An index past the end of the base register continues into the next register. For example, byte 9 from register 0 is lane 1 of register 1, and doubleword 1 from register 0 is register 1.
- R5: Accesses at different widths alias the same bytes. For example, word 1 of register 0 covers halfwords 2 and 3 of register 0.
- R6: A write changes only the bytes of the addressed element. Every other byte keeps its value.
- R7: A read narrower than 64 bits returns the element in the low bits, and all higher bits are zero.
- R8: If the computed register number is 127 or more beyond... more precisely, at least 128, the port's error output is 1. A write in that case changes no byte, and a read in that case returns zero.
- R9: Reads are combinational. A write becomes visible only after the rising clock edge at which wr_en is 1.
- R10: Bits of wr_data above the element width have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears the store |
| rd_base | input | 7 | Read base register |
| rd_idx | input | 10 | Read element index |
| rd_width | input | 2 | Read element width code |
| rd_data | output | 64 | Read element, zero-extended |
| rd_err | output | 1 | Read address lies past the last register |
| wr_en | input | 1 | Write request |
| wr_base | input | 7 | Write base register |
| wr_idx | input | 10 | Write element index |
| wr_width | input | 2 | Write element width code |
| wr_data | input | 64 | Write element in the low bits |
| wr_err | output | 1 | Write address lies past the last register |

## Verification
The walked vectors write at one width and read back at another. This separates a correct lane computation from one that ignores the scaling, and a correct spill into the next register from one that wraps inside the base register. Writes that partly overwrite earlier data show whether neighbouring bytes are kept. A write with junk in its upper bits shows whether the width mask is applied. Directed cases push the index to the last valid byte and one step past it, where an error must be raised and a truncated register number must not be written.

// File: rtl/ear_pkg.sv
package ear_pkg;

  typedef enum logic [1:0] {
    EW_BYTE  = 2'd0,
    EW_HALF  = 2'd1,
    EW_WORD  = 2'd2,
    EW_DWORD = 2'd3
  } ew_e;

  // flat byte offset of an element (R2)
  function automatic logic [31:0] elem_byte_off(input logic [31:0] base,
                                                input logic [31:0] idx,
                                                input logic [1:0]  w);
    return (base << 3) + (idx << w);
  endfunction

  // byte enables of an element that starts in a given lane
  function automatic logic [7:0] lane_be(input logic [2:0] lane,
                                         input logic [1:0] w);
    logic [8:0] span;
    span = (9'd1 << (4'd1 << w)) - 9'd1;
    return span[7:0] << lane;
  endfunction

  // value mask of an element in the low bits (R7, R10)
  function automatic logic [63:0] elem_mask(input logic [1:0] w);
    logic [63:0] m;
    if (w == EW_DWORD) m = '1;
    else               m = (64'd1 << (7'd8 << w)) - 64'd1;
    return m;
  endfunction

endpackage

// File: rtl/ear_addr_gen.sv
module ear_addr_gen #(
  parameter int NUM_REGS = 128,
  parameter int RA_W     = $clog2(NUM_REGS),
  parameter int IDX_W    = $clog2(NUM_REGS * 8)
) (
  input  logic [RA_W-1:0]  base,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       width,
  output logic [RA_W-1:0]  reg_sel,
  output logic [2:0]       lane,
  output logic             err
);
  import ear_pkg::*;

  logic [31:0] off;
  logic [31:0] reg_num;

  always_comb begin
    off     = elem_byte_off(32'(base), 32'(idx), width);
    reg_num = off >> 3;
    lane    = off[2:0];
    err     = (reg_num >= 32'(NUM_REGS));
    reg_sel = reg_num[RA_W-1:0];
  end

endmodule

// File: rtl/ear_store.sv
module ear_store #(
  parameter int NUM_REGS = 128,
  parameter int RA_W     = $clog2(NUM_REGS),
  parameter int LANES    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [RA_W-1:0]    wr_reg,
  input  logic [LANES-1:0]   be,
  input  logic [LANES*8-1:0] wdata,
  input  logic [RA_W-1:0]    rd_reg,
  output logic [LANES*8-1:0] rdata
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] bank [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < NUM_REGS; r++) bank[r] <= '0;
      end else if (we && be[l]) begin
        bank[wr_reg] <= wdata[8*l +: 8];
      end
    end

    assign rdata[8*l +: 8] = bank[rd_reg];
  end

endmodule

// File: rtl/ear_read_align.sv
module ear_read_align (
  input  logic [63:0] word,
  input  logic [2:0]  lane,
  input  logic [1:0]  width,
  input  logic        err,
  output logic [63:0] data
);
  import ear_pkg::*;

  always_comb begin
    if (err) data = '0;
    else     data = (word >> {lane, 3'b000}) & elem_mask(width);
  end

endmodule

// File: rtl/elem_regfile.sv
module elem_regfile #(
  parameter int NUM_REGS = 128,
  parameter int RA_W     = $clog2(NUM_REGS),
  parameter int IDX_W    = $clog2(NUM_REGS * 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RA_W-1:0]  rd_base,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [1:0]       rd_width,
  output logic [63:0]      rd_data,
  output logic             rd_err,
  input  logic             wr_en,
  input  logic [RA_W-1:0]  wr_base,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_width,
  input  logic [63:0]      wr_data,
  output logic             wr_err
);
  import ear_pkg::*;

  // named internal events, observed by the checker
  logic [RA_W-1:0] rd_reg;
  logic [2:0]      rd_lane;
  logic [RA_W-1:0] wr_reg;
  logic [2:0]      wr_lane;
  logic [7:0]      wr_be;
  logic [63:0]     wr_lane_data;
  logic            wr_commit;
  logic [63:0]     rd_word;

  ear_addr_gen #(.NUM_REGS(NUM_REGS), .RA_W(RA_W), .IDX_W(IDX_W)) u_rd_addr (
    .base(rd_base), .idx(rd_idx), .width(rd_width),
    .reg_sel(rd_reg), .lane(rd_lane), .err(rd_err)
  );

  ear_addr_gen #(.NUM_REGS(NUM_REGS), .RA_W(RA_W), .IDX_W(IDX_W)) u_wr_addr (
    .base(wr_base), .idx(wr_idx), .width(wr_width),
    .reg_sel(wr_reg), .lane(wr_lane), .err(wr_err)
  );

  assign wr_commit    = wr_en & ~wr_err;
  assign wr_be        = lane_be(wr_lane, wr_width);
  assign wr_lane_data = (wr_data & elem_mask(wr_width)) << {wr_lane, 3'b000};

  ear_store #(.NUM_REGS(NUM_REGS), .RA_W(RA_W), .LANES(8)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(wr_commit), .wr_reg(wr_reg), .be(wr_be), .wdata(wr_lane_data),
    .rd_reg(rd_reg), .rdata(rd_word)
  );

  ear_read_align u_align (
    .word(rd_word), .lane(rd_lane), .width(rd_width), .err(rd_err),
    .data(rd_data)
  );

endmodule

// File: rtl/ear_checker.sv
module ear_checker #(
  parameter int RA_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_err,
  input logic [63:0]     rd_data,
  input logic [1:0]      rd_width,
  input logic [RA_W-1:0] rd_reg,
  input logic [2:0]      rd_lane,
  input logic            wr_commit,
  input logic [7:0]      wr_be,
  input logic [1:0]      wr_width,
  input logic [RA_W-1:0] wr_reg,
  input logic [2:0]      wr_lane,
  input logic [63:0]     wr_data
);
  import ear_pkg::*;

  // R8: erroneous read yields zero
  a_r8_err_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rd_data == 64'd0);

  // R7: high bits of a narrow read are zero
  a_r7_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_width != EW_DWORD) |-> (rd_data & ~elem_mask(rd_width)) == 64'd0);

  // R6: a write enables exactly as many lanes as the element has bytes
  a_r6_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $countones(wr_be) == (32'd1 << wr_width));

  // R9: a committed element reads back after the edge
  a_r9_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_commit) && !rd_err && rd_reg == $past(wr_reg) &&
     rd_lane == $past(wr_lane) && rd_width == $past(wr_width))
    |-> rd_data == ($past(wr_data) & elem_mask(rd_width)));

endmodule

bind elem_regfile ear_checker #(.RA_W(RA_W)) u_ear_checker (
  .clk(clk), .rst_n(rst_n), .rd_err(rd_err), .rd_data(rd_data),
  .rd_width(rd_width), .rd_reg(rd_reg), .rd_lane(rd_lane),
  .wr_commit(wr_commit), .wr_be(wr_be), .wr_width(wr_width),
  .wr_reg(wr_reg), .wr_lane(wr_lane), .wr_data(wr_data)
);

// File: tb/test_elem_regfile.sv
module test_elem_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  rd_base = '0;
  logic [9:0]  rd_idx = '0;
  logic [1:0]  rd_width = '0;
  logic [63:0] rd_data;
  logic        rd_err;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_base = '0;
  logic [9:0]  wr_idx = '0;
  logic [1:0]  wr_width = '0;
  logic [63:0] wr_data = '0;
  logic        wr_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  elem_regfile i_elem_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_base(rd_base), .rd_idx(rd_idx), .rd_width(rd_width),
    .rd_data(rd_data), .rd_err(rd_err),
    .wr_en(wr_en), .wr_base(wr_base), .wr_idx(wr_idx),
    .wr_width(wr_width), .wr_data(wr_data), .wr_err(wr_err)
  );

  // vector table: optional write, then a read with its expected value
  localparam int NV = 9;
  localparam logic        T_WE [NV] = '{1, 0, 1, 1, 0, 1, 1, 0, 1};
  localparam logic [6:0]  T_WB [NV] = '{0, 0, 0, 0, 0, 2, 0, 0, 0};
  localparam logic [9:0]  T_WI [NV] = '{0, 0, 9, 1, 0, 5, 127, 0, 2};
  localparam logic [1:0]  T_WW [NV] = '{3, 0, 0, 2, 0, 1, 3, 0, 2};
  localparam logic [63:0] T_WD [NV] = '{
    64'h8877665544332211, 64'h0, 64'hAB, 64'hDEADBEEF, 64'h0,
    64'hFFFFFFFFFFFF1234, 64'h0123456789ABCDEF, 64'h0, 64'h55};
  localparam logic [6:0]  T_RB [NV] = '{0, 0, 1, 0, 0, 3, 126, 127, 1};
  localparam logic [9:0]  T_RI [NV] = '{3, 2, 0, 3, 0, 0, 1, 7, 0};
  localparam logic [1:0]  T_RW [NV] = '{0, 1, 3, 1, 3, 3, 3, 0, 3};
  localparam logic [63:0] T_EX [NV] = '{
    64'h44, 64'h6655, 64'hAB00, 64'hDEAD, 64'hDEADBEEF44332211,
    64'h12340000, 64'h0123456789ABCDEF, 64'h01, 64'h55};
  localparam string T_REQ [NV] = '{"R2 R3", "R5", "R4", "R5", "R6",
                                   "R10 R4", "R4", "R2", "R6"};

  task automatic check(input string req, input logic [63:0] got,
                       input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] b, input logic [9:0] i,
                          input logic [1:0] w, input logic [63:0] d);
    @(negedge clk);
    wr_base = b; wr_idx = i; wr_width = w; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic set_read(input logic [6:0] b, input logic [9:0] i,
                          input logic [1:0] w);
    @(negedge clk);
    rd_base = b; rd_idx = i; rd_width = w;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    set_read(7'd0, 10'd0, 2'd3);
    check("R1 r0", rd_data, 64'd0);
    set_read(7'd64, 10'd0, 2'd3);
    check("R1 r64", rd_data, 64'd0);

    for (int v = 0; v < NV; v++) begin
      if (T_WE[v]) do_write(T_WB[v], T_WI[v], T_WW[v], T_WD[v]);
      set_read(T_RB[v], T_RI[v], T_RW[v]);
      check(T_REQ[v], rd_data, T_EX[v]);
      check({T_REQ[v], " err"}, {63'd0, rd_err}, 64'd0);
    end

    // R8 write past the end: r127 byte 8 -> register 128
    @(negedge clk);
    wr_base = 7'd127; wr_idx = 10'd8; wr_width = 2'd0; wr_data = 64'hEE;
    wr_en = 1'b1;
    #1 check("R8 wr_err", {63'd0, wr_err}, 64'd1);
    @(posedge clk);
    #1 wr_en = 1'b0;
    set_read(7'd0, 10'd0, 2'd3);
    check("R8 r0 untouched", rd_data, 64'hDEADBEEF44332211);
    set_read(7'd127, 10'd0, 2'd3);
    check("R8 r127 untouched", rd_data, 64'h0123456789ABCDEF);

    // R8 read past the end
    set_read(7'd120, 10'd8, 2'd3);
    check("R8 rd_err", {63'd0, rd_err}, 64'd1);
    check("R8 rd zero", rd_data, 64'd0);

    // R4 R2 last valid byte from r0
    set_read(7'd0, 10'd1023, 2'd0);
    check("R4 last byte", rd_data, 64'h01);
    check("R4 last byte err", {63'd0, rd_err}, 64'd0);

    // R9 visible only after the edge
    set_read(7'd5, 10'd0, 2'd3);
    @(negedge clk);
    wr_base = 7'd5; wr_idx = 10'd0; wr_width = 2'd3; wr_data = 64'hCAFE;
    wr_en = 1'b1;
    #1 check("R9 before edge", rd_data, 64'd0);
    @(posedge clk);
    #1 wr_en = 1'b0;
    check("R9 after edge", rd_data, 64'hCAFE);

    // R1 reset again clears
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    set_read(7'd0, 10'd0, 2'd3);
    check("R1 r0 after reset", rd_data, 64'd0);
    set_read(7'd127, 10'd0, 2'd3);
    check("R1 r127 after reset", rd_data, 64'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule